// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block drives the control-transfer sequences of an 8-bit processor whose stack lives in page 1. It performs the power-on start-up sequence, the entry into a non-maskable interrupt, a maskable interrupt and a software break, and the two return sequences: return-from-interrupt and return-from-subroutine. At the start of each event it takes the processor's current program counter, stack pointer and status byte from its inputs. It then moves bytes to and from memory through a byte-wide port, one access per cycle at most. When the sequence ends it presents the updated program counter, stack pointer and status byte on its outputs.

The memory port reads combinationally. The block drives an address with the read strobe, and the byte on `mem_rdata` is taken at the clock edge that ends that cycle. Writes are single-cycle strobes. Each event has a fixed length, and `busy` is high for exactly that many cycles. Start requests that arrive while the block is busy are dropped. The only exception is a non-maskable request edge, which is latched and served after the current sequence. Instruction fetch and decode are outside the block.

Top module: `trap_sequencer`

## Requirements
- R1: After `rst_n` is released, `busy` stays high for 6 cycles, counting the cycle in which `rst_n` first reads high. Steps 4 and 5 read addresses 0xFFFC and then 0xFFFD. The outputs end as PC = {byte@FFFD, byte@FFFC}, S = 0xFF and P = 0x26, where bit 2 is the interrupt mask, bit 1 is zero and bit 5 is the constant one. While `rst_n` is low, `busy` = 1, S = 0xFF and no strobe is active.
- R2: A push writes address {0x01, S} and then decrements S. A pull first increments S and then reads {0x01, S}. The low byte wraps within the page.
- R3: A rising edge on `nmi_req` starts a 7-cycle entry, whatever the interrupt mask. The entry writes PC[15:8], then PC[7:0], then P with bit 4 (break) cleared and bit 5 set. It then reads 0xFFFA and 0xFFFB into PC. The final P has bit 2 set and bit 4 clear, and S is decremented by 3.
- R4: `irq_req` high while P bit 2 is clear starts the same 7-cycle entry as R3, but reads the vector at 0xFFFE and 0xFFFF.
- R5: `irq_req` high while P bit 2 is set costs 7 busy cycles with no memory strobe. PC, S and P come out equal to their inputs, apart from bit 5.
- R6: When several requests are present in the same idle cycle, the block serves them in this order: a non-maskable edge, then `irq_req` (masked or not), then `brk_start`, then `rti_start`, then `rts_start`.
- R7: `brk_start` starts a 7-cycle sequence. It pushes PC+1 (16-bit wrap), high byte first, then P with bits 4 and 5 set. It then sets bit 2 and loads PC from 0xFFFE and 0xFFFF.
- R8: `rti_start` starts a 6-cycle sequence that pulls P, then PC[7:0], then PC[15:8]. The final P is the pulled byte with bits 4 and 5 forced to 1.
- R9: `rts_start` starts a 6-cycle sequence that pulls PC[7:0] and then PC[15:8]. The final PC is the pulled value plus 1, with a 16-bit wrap.
- R10: Bit 5 of `p_out` is 1 at all times after reset.
- R11: A held `nmi_req` causes a single entry. Start requests raised while the block is busy are ignored, but a non-maskable edge seen while busy is taken one cycle after `busy` falls.
- R12: `mem_we` and `mem_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the start-up sequence |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| irq_req | input | 1 | Maskable request, level-sensitive |
| brk_start | input | 1 | Start a software break |
| rti_start | input | 1 | Start a return-from-interrupt |
| rts_start | input | 1 | Start a return-from-subroutine |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| pc_out | output | 16 | Program counter after the sequence |
| sp_out | output | 8 | Stack pointer after the sequence |
| p_out | output | 8 | Status byte after the sequence |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_re` is high |
| busy | output | 1 | High while a sequence runs |

## Verification
The assertions assume that the processor holds `pc_in`, `sp_in` and `p_in` steady in the cycle a request is taken. They also assume that the memory returns read data in the same cycle the read strobe is high, and that the processor uses `p_out` only when `busy` is low. The bench drives all inputs only on falling edges and holds the state inputs across each start. It models stack memory that reads back exactly what the block wrote, and it builds the return sequences on bytes that an earlier entry pushed. As a result, every pull sees data whose origin is known.

// File: rtl/trap_pkg.sv
// Shared encodings for the interrupt and reset sequencer.
// Assumes a byte-wide memory, a 16-bit address and an 8-bit stack pointer.
package trap_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    localparam int ENTRY_CYCLES  = 7;
    localparam int RESET_CYCLES  = 6;
    localparam int RETURN_CYCLES = 6;

    localparam int FLAG_Z   = 1;
    localparam int FLAG_I   = 2;
    localparam int FLAG_B   = 4;
    localparam int FLAG_ONE = 5;

    localparam logic [DATA_W-1:0] MASK_I   = DATA_W'(1 << FLAG_I);
    localparam logic [DATA_W-1:0] MASK_B   = DATA_W'(1 << FLAG_B);
    localparam logic [DATA_W-1:0] MASK_ONE = DATA_W'(1 << FLAG_ONE);
    localparam logic [DATA_W-1:0] RESET_P  = MASK_ONE | MASK_I | DATA_W'(1 << FLAG_Z);

    typedef enum logic [2:0] {
        EV_RESET, EV_NMI, EV_IRQ, EV_BRK, EV_SKIP, EV_RTI, EV_RTS
    } ev_kind_t;

    typedef enum logic [3:0] {
        AC_NONE, AC_PUSH_PCH, AC_PUSH_PCL, AC_PUSH_P,
        AC_PULL_P, AC_PULL_PCL, AC_PULL_PCH,
        AC_VEC_LO, AC_VEC_HI, AC_PC_INC
    } act_t;

    // Index of the final step of an event
    function automatic logic [STEP_W-1:0] ev_last(ev_kind_t k);
        case (k)
            EV_RESET:       ev_last = STEP_W'(RESET_CYCLES - 1);
            EV_RTI, EV_RTS: ev_last = STEP_W'(RETURN_CYCLES - 1);
            default:        ev_last = STEP_W'(ENTRY_CYCLES - 1);
        endcase
    endfunction

    // Memory or register action performed at a given step of an event
    function automatic act_t act_of(ev_kind_t k, logic [STEP_W-1:0] s);
        act_of = AC_NONE;
        case (k)
            EV_NMI, EV_IRQ, EV_BRK: begin
                case (s)
                    3'd2: act_of = AC_PUSH_PCH;
                    3'd3: act_of = AC_PUSH_PCL;
                    3'd4: act_of = AC_PUSH_P;
                    3'd5: act_of = AC_VEC_LO;
                    3'd6: act_of = AC_VEC_HI;
                    default: act_of = AC_NONE;
                endcase
            end
            EV_RESET: begin
                case (s)
                    3'd4: act_of = AC_VEC_LO;
                    3'd5: act_of = AC_VEC_HI;
                    default: act_of = AC_NONE;
                endcase
            end
            EV_RTI: begin
                case (s)
                    3'd2: act_of = AC_PULL_P;
                    3'd3: act_of = AC_PULL_PCL;
                    3'd4: act_of = AC_PULL_PCH;
                    default: act_of = AC_NONE;
                endcase
            end
            EV_RTS: begin
                case (s)
                    3'd2: act_of = AC_PULL_PCL;
                    3'd3: act_of = AC_PULL_PCH;
                    3'd5: act_of = AC_PC_INC;
                    default: act_of = AC_NONE;
                endcase
            end
            default: act_of = AC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/trap_nmi_latch.sv
// Non-maskable request edge latch.
// Detects a rising edge on the request line and holds it pending until
// the sequencer consumes it. A new edge in the consuming cycle is itself
// consumed, because the taken signal already includes it.
module trap_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic consume,
    output logic taken
);
    logic prev_q;
    logic pend_q;

    assign taken = pend_q | (nmi_req & ~prev_q);

    // Track the previous level and keep an unserved edge pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_req;
            pend_q <= taken & ~consume;
        end
    end
endmodule

// File: rtl/trap_arbiter.sv
// Fixed-priority request selection.
// Assumes the requests are only sampled when the sequencer is idle.
// A masked maskable request still wins and becomes a no-access event.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic     busy,
    input  logic     nmi_take,
    input  logic     irq_req,
    input  logic     mask_i,
    input  logic     brk_start,
    input  logic     rti_start,
    input  logic     rts_start,
    output logic     start,
    output ev_kind_t start_kind
);
    // Pick the highest-priority request present in an idle cycle
    always_comb begin
        start = !busy && (nmi_take || irq_req || brk_start || rti_start || rts_start);
        if (nmi_take)       start_kind = EV_NMI;
        else if (irq_req)   start_kind = mask_i ? EV_SKIP : EV_IRQ;
        else if (brk_start) start_kind = EV_BRK;
        else if (rti_start) start_kind = EV_RTI;
        else                start_kind = EV_RTS;
    end
endmodule

// File: rtl/trap_stepper.sv
// Step counter for one event at a time.
// Holds the event kind and a step index. It is busy from the cycle after a
// start until the last step of that kind, and it enters the start-up
// sequence while reset is held.
module trap_stepper
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ev_kind_t          start_kind,
    output logic              busy,
    output ev_kind_t          kind,
    output logic [STEP_W-1:0] step
);
    logic              busy_q;
    ev_kind_t          kind_q;
    logic [STEP_W-1:0] step_q;

    assign busy = busy_q;
    assign kind = kind_q;
    assign step = step_q;

    // Advance the step index, finish on the last step, accept a new event when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            kind_q <= EV_RESET;
            step_q <= '0;
        end else if (busy_q) begin
            if (step_q == ev_last(kind_q)) busy_q <= 1'b0;
            else                           step_q <= step_q + 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            kind_q <= start_kind;
            step_q <= '0;
        end
    end
endmodule

// File: rtl/trap_sequencer.sv
// Interrupt, break, reset and return sequencer (top).
// Captures PC, S and P from its inputs when an event starts, performs the
// stack and vector accesses of that event over a fixed number of cycles,
// and holds the results on its outputs. Assumes the memory read is
// combinational and the vectors sit at even addresses.
module trap_sequencer
    import trap_pkg::*;
#(
    parameter logic [15:0] NMI_VECTOR = 16'hFFFA,
    parameter logic [15:0] RST_VECTOR = 16'hFFFC,
    parameter logic [15:0] IRQ_VECTOR = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              brk_start,
    input  logic              rti_start,
    input  logic              rts_start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] p_in,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] p_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy
);
    localparam int HALF_W = ADDR_W / 2;

    logic              nmi_take;
    logic              start;
    ev_kind_t          start_kind;
    ev_kind_t          kind;
    logic [STEP_W-1:0] step;
    act_t              act;
    logic [ADDR_W-1:0] vec_base;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] p_q;
    logic [DATA_W-1:0] sp_up;

    trap_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .consume (start && start_kind == EV_NMI),
        .taken   (nmi_take)
    );

    trap_arbiter u_arb (
        .busy       (busy),
        .nmi_take   (nmi_take),
        .irq_req    (irq_req),
        .mask_i     (p_in[FLAG_I]),
        .brk_start  (brk_start),
        .rti_start  (rti_start),
        .rts_start  (rts_start),
        .start      (start),
        .start_kind (start_kind)
    );

    trap_stepper u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .busy       (busy),
        .kind       (kind),
        .step       (step)
    );

    // Decode the action of the current step and the vector of the current event
    always_comb begin
        act = busy ? act_of(kind, step) : AC_NONE;
        case (kind)
            EV_RESET: vec_base = RST_VECTOR;
            EV_NMI:   vec_base = NMI_VECTOR;
            default:  vec_base = IRQ_VECTOR;
        endcase
        sp_up = sp_q + 1'b1;
    end

    // Drive the memory port for the current action
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        case (act)
            AC_PUSH_PCH: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[ADDR_W-1:HALF_W]; mem_we = 1'b1;
            end
            AC_PUSH_PCL: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[HALF_W-1:0]; mem_we = 1'b1;
            end
            AC_PUSH_P: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_wdata = p_q | MASK_ONE; mem_we = 1'b1;
            end
            AC_PULL_P, AC_PULL_PCL, AC_PULL_PCH: begin
                mem_addr = {STACK_PAGE, sp_up}; mem_re = 1'b1;
            end
            AC_VEC_LO: begin
                mem_addr = vec_base; mem_re = 1'b1;
            end
            AC_VEC_HI: begin
                mem_addr = vec_base + 1'b1; mem_re = 1'b1;
            end
            default: ;
        endcase
    end

    // Architectural state: load at start, then update per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '1;
            p_q  <= RESET_P;
        end else if (start) begin
            pc_q <= (start_kind == EV_BRK) ? pc_in + 1'b1 : pc_in;
            sp_q <= sp_in;
            case (start_kind)
                EV_BRK:         p_q <= p_in | MASK_B;
                EV_NMI, EV_IRQ: p_q <= p_in & ~MASK_B;
                default:        p_q <= p_in;
            endcase
        end else begin
            case (act)
                AC_PUSH_PCH, AC_PUSH_PCL: sp_q <= sp_q - 1'b1;
                AC_PUSH_P: begin
                    sp_q <= sp_q - 1'b1;
                    p_q  <= p_q | MASK_I;
                end
                AC_PULL_P: begin
                    sp_q <= sp_up;
                    p_q  <= mem_rdata | MASK_B;
                end
                AC_PULL_PCL: begin
                    sp_q <= sp_up;
                    pc_q[HALF_W-1:0] <= mem_rdata;
                end
                AC_PULL_PCH: begin
                    sp_q <= sp_up;
                    pc_q[ADDR_W-1:HALF_W] <= mem_rdata;
                end
                AC_VEC_LO: pc_q[HALF_W-1:0] <= mem_rdata;
                AC_VEC_HI: pc_q[ADDR_W-1:HALF_W] <= mem_rdata;
                AC_PC_INC: pc_q <= pc_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign pc_out = pc_q;
    assign sp_out = sp_q;
    assign p_out  = p_q | MASK_ONE;
endmodule

// File: rtl/trap_sequencer_chk.sv
// Port-level property checker for the sequencer, attached by bind.
// Assumes the processor holds the state inputs while busy.
module trap_sequencer_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [7:0]  sp_out,
    input logic [7:0]  p_out
);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R2
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == {STACK_PAGE, sp_out});

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == 8'($past(sp_out) - 8'd1));

    // R2
    pull_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[15:8] == STACK_PAGE) |-> mem_addr[7:0] == 8'(sp_out + 8'd1));

    // R2
    pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[15:8] == STACK_PAGE) |=> sp_out == 8'($past(sp_out) + 8'd1));

    // R10
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_out[5]);
endmodule

bind trap_sequencer trap_sequencer_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_out   (sp_out),
    .p_out    (p_out)
);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, nmi_req, irq_req, brk_start, rti_start, rts_start;
    logic [15:0] pc_in;
    logic [7:0]  sp_in, p_in;
    logic [15:0] pc_out, mem_addr;
    logic [7:0]  sp_out, p_out, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, busy;

    trap_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .brk_start(brk_start), .rti_start(rti_start), .rts_start(rts_start),
        .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
        .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy)
    );

    // Memory model: page 1 stack plus three vectors
    logic [7:0] stk [256] = '{default: 8'h00};

    function automatic logic [7:0] vec_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: vec_byte = 8'h11;
            16'hFFFB: vec_byte = 8'h22;
            16'hFFFC: vec_byte = 8'h00;
            16'hFFFD: vec_byte = 8'hC0;
            16'hFFFE: vec_byte = 8'h34;
            16'hFFFF: vec_byte = 8'hE1;
            default:  vec_byte = 8'h00;
        endcase
    endfunction

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vec_byte(mem_addr);

    // Access log, sampled away from the active edge
    logic [15:0] la [16];
    logic [7:0]  ld [16];
    logic        lw [16];
    int          ln = 0;

    always @(negedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        if (mem_we || mem_re) begin
            la[ln % 16] = mem_addr;
            ld[ln % 16] = mem_we ? mem_wdata : mem_rdata;
            lw[ln % 16] = mem_we;
            ln = ln + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare one logged access {write, address, data}
    task automatic chk_log(input string tag, input int base, input int i,
                           input logic w, input logic [15:0] a, input logic [7:0] d);
        int k;
        k = (base + i) % 16;
        chk(tag, {7'd0, lw[k], la[k], ld[k]}, {7'd0, w, a, d});
    endtask

    // Drive one set of requests for a single rising edge and count busy cycles
    task automatic fire(input logic n, input logic i, input logic b, input logic ti,
                        input logic ts, input logic [15:0] pc, input logic [7:0] sp,
                        input logic [7:0] p, output int cyc, output int base);
        @(negedge clk);
        nmi_req = n; irq_req = i; brk_start = b; rti_start = ti; rts_start = ts;
        pc_in = pc; sp_in = sp; p_in = p;
        base = ln;
        @(negedge clk);
        irq_req = 0; brk_start = 0; rti_start = 0; rts_start = 0;
        cyc = 0;
        while (busy && cyc < 20) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run still reaches the summary line
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        int cyc, base, base2, cnt;
        logic [15:0] pc, pcn;
        logic [7:0]  sp, p, pe;

        rst_n = 0; nmi_req = 0; irq_req = 0; brk_start = 0; rti_start = 0; rts_start = 0;
        pc_in = 0; sp_in = 0; p_in = 0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1);
        chk("R1 S in reset", sp_out, 8'hFF);
        chk("R12 no strobe in reset", {mem_we, mem_re}, 0);

        // R1 start-up sequence
        base = ln;
        rst_n = 1;
        cyc = 1;
        @(negedge clk);
        while (busy && cyc < 20) begin cyc++; @(negedge clk); end
        chk("R1 start-up cycles", cyc, 6);
        chk("R1 access count", ln - base, 2);
        chk_log("R1 vector low", base, 0, 0, 16'hFFFC, 8'h00);
        chk_log("R1 vector high", base, 1, 0, 16'hFFFD, 8'hC0);
        chk("R1 PC", pc_out, 16'hC000);
        chk("R1 S", sp_out, 8'hFF);
        chk("R1 P", p_out, 8'h26);

        // R4 and R9 sweep over every stack pointer value
        for (int s = 0; s < 256; s++) begin
            sp = 8'(s);
            pc = 16'(s * 257) ^ 16'h1234;
            p  = (sp ^ 8'h5A) & ~8'h04;
            pe = (p & ~8'h10) | 8'h20;
            fire(0, 1, 0, 0, 0, pc, sp, p, cyc, base);
            chk("R4 entry cycles", cyc, 7);
            chk("R4 access count", ln - base, 5);
            chk_log("R4 push PC high", base, 0, 1, {8'h01, sp}, pc[15:8]);
            chk_log("R4 push PC low", base, 1, 1, {8'h01, 8'(sp - 8'd1)}, pc[7:0]);
            chk_log("R4 push P break clear", base, 2, 1, {8'h01, 8'(sp - 8'd2)}, pe);
            chk_log("R4 vector low", base, 3, 0, 16'hFFFE, 8'h34);
            chk_log("R4 vector high", base, 4, 0, 16'hFFFF, 8'hE1);
            chk("R4 PC", pc_out, 16'hE134);
            chk("R2 S after three pushes", sp_out, 8'(sp - 8'd3));
            chk("R4 P mask set", p_out, pe | 8'h04);
            fire(0, 0, 0, 0, 1, 16'h0000, 8'(sp - 8'd2), 8'h00, cyc, base);
            chk("R9 return cycles", cyc, 6);
            chk_log("R9 pull PC low", base, 0, 0, {8'h01, 8'(sp - 8'd1)}, pc[7:0]);
            chk_log("R9 pull PC high", base, 1, 0, {8'h01, sp}, pc[15:8]);
            chk("R9 PC plus one", pc_out, 16'(pc + 16'd1));
            chk("R2 S after two pulls", sp_out, sp);
        end

        // R9 16-bit wrap of the returned PC
        fire(0, 1, 0, 0, 0, 16'hFFFF, 8'h00, 8'h00, cyc, base);
        fire(0, 0, 0, 0, 1, 16'h0000, 8'hFE, 8'h00, cyc, base);
        chk_log("R2 pull wraps in page", base, 1, 0, 16'h0100, 8'hFF);
        chk("R9 PC wraps to zero", pc_out, 16'h0000);
        chk("R9 S", sp_out, 8'h00);

        // R7 and R8: break then return-from-interrupt
        for (int j = 0; j < 16; j++) begin
            pc  = (j == 15) ? 16'hFFFF : 16'(j * 16'h1111 + 16'h0203);
            sp  = 8'(j * 17 + 3);
            p   = 8'(j * 13) & ~8'h04;
            pcn = 16'(pc + 16'd1);
            pe  = p | 8'h30;
            fire(0, 0, 1, 0, 0, pc, sp, p, cyc, base);
            chk("R7 break cycles", cyc, 7);
            chk_log("R7 push PC+1 high", base, 0, 1, {8'h01, sp}, pcn[15:8]);
            chk_log("R7 push PC+1 low", base, 1, 1, {8'h01, 8'(sp - 8'd1)}, pcn[7:0]);
            chk_log("R7 push P break set", base, 2, 1, {8'h01, 8'(sp - 8'd2)}, pe);
            chk_log("R7 vector low", base, 3, 0, 16'hFFFE, 8'h34);
            chk("R7 PC", pc_out, 16'hE134);
            chk("R7 P", p_out, pe | 8'h04);
            fire(0, 0, 0, 1, 0, 16'h0000, 8'(sp - 8'd3), 8'h04, cyc, base);
            chk("R8 return cycles", cyc, 6);
            chk("R8 access count", ln - base, 3);
            chk_log("R8 pull P first", base, 0, 0, {8'h01, 8'(sp - 8'd2)}, pe);
            chk("R8 PC", pc_out, pcn);
            chk("R8 S", sp_out, sp);
            chk("R8 P", p_out, pe);
        end

        // R3 non-maskable entry with the mask set, request held high
        fire(1, 0, 0, 0, 0, 16'h4455, 8'h80, 8'h17, cyc, base);
        chk("R3 entry cycles", cyc, 7);
        chk_log("R3 push PC high", base, 0, 1, 16'h0180, 8'h44);
        chk_log("R3 push P break clear", base, 2, 1, 16'h017E, 8'h27);
        chk_log("R3 vector low", base, 3, 0, 16'hFFFA, 8'h11);
        chk_log("R3 vector high", base, 4, 0, 16'hFFFB, 8'h22);
        chk("R3 PC", pc_out, 16'h2211);
        chk("R3 P", p_out, 8'h27);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); if (busy) cnt++; end
        chk("R11 held request enters once", cnt, 0);
        nmi_req = 0;

        // R5 masked request: time consumed, nothing touched
        fire(0, 1, 0, 0, 0, 16'h1357, 8'h42, 8'h04, cyc, base);
        chk("R5 masked cycles", cyc, 7);
        chk("R5 no access", ln - base, 0);
        chk("R5 PC", pc_out, 16'h1357);
        chk("R5 S", sp_out, 8'h42);
        chk("R10 P bit 5 forced", p_out, 8'h24);

        // R6 priority among simultaneous requests
        fire(1, 1, 1, 1, 1, 16'h0A0B, 8'hF0, 8'h00, cyc, base);
        chk_log("R6 edge over all", base, 3, 0, 16'hFFFA, 8'h11);
        nmi_req = 0;
        fire(0, 1, 1, 1, 1, 16'h0A0B, 8'hF0, 8'h00, cyc, base);
        chk_log("R6 maskable over break", base, 1, 1, 16'h01EF, 8'h0B);
        chk_log("R6 maskable pushes break clear", base, 2, 1, 16'h01EE, 8'h20);
        fire(0, 1, 1, 0, 0, 16'h0A0B, 8'hF0, 8'h04, cyc, base);
        chk("R6 masked request over break", ln - base, 0);
        fire(0, 0, 1, 1, 1, 16'h0A0B, 8'hF0, 8'h00, cyc, base);
        chk_log("R6 break over returns", base, 1, 1, 16'h01EF, 8'h0C);
        fire(0, 0, 0, 1, 1, 16'h0000, 8'hED, 8'h00, cyc, base);
        chk("R6 interrupt return over subroutine return", ln - base, 3);

        // R11 requests while busy: break dropped, edge kept
        @(negedge clk);
        irq_req = 1; pc_in = 16'h7788; sp_in = 8'h60; p_in = 8'h00;
        @(negedge clk);
        irq_req = 0; brk_start = 1; nmi_req = 1;
        @(negedge clk);
        brk_start = 0; nmi_req = 0;
        cyc = 0;
        while (busy && cyc < 20) begin cyc++; @(negedge clk); end
        base2 = ln;
        cnt = 0;
        while (!busy && cnt < 5) begin cnt++; @(negedge clk); end
        chk("R11 latched edge served after one idle cycle", cnt, 1);
        while (busy && cnt < 30) begin cnt++; @(negedge clk); end
        chk_log("R11 latched edge uses its vector", base2, 3, 0, 16'hFFFA, 8'h11);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); if (busy) cnt++; end
        chk("R11 break while busy dropped", cnt, 0);
        chk("R12 idle quiet", {mem_we, mem_re}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule